// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block turns a short packet into line states on a low-speed USB differential pair. A client pulses `start_i` with a payload length and a packet-kind flag, then streams the payload bytes over a ready/valid interface. The block inserts the sync byte itself. It serializes every byte least significant bit first, applies NRZI coding with bit stuffing, and closes the packet with an end-of-packet sequence. Bit timing comes from an internal divider that produces one line bit every `CLKS_PER_BIT` system clocks.

The block owns the pair's output enable. It presents the idle (J) level before it turns the drivers on. After the end-of-packet sequence it turns them off and leaves both data lines low, so no pull-up is asserted. A packet is flagged either as a handshake, which carries exactly one byte after sync, or as a data packet. A new device address on `new_addr_i` is taken into the active address register only when a data packet completes.

Top module: `lsusb_tx`

## Requirements
- R1: After reset, and whenever no packet is in progress, `busy_o`, `oe_o`, `dp_o`, `dm_o`, `in_ready_o` and `done_o` are all 0. `dev_addr_o` resets to 0.
- R2: `start_i` is accepted only while idle. For a data packet (`is_data_i`=1), `len_i` is the payload byte count excluding sync and must lie in 1..11 (2..12 bytes on the wire). A start with any other length, or a start while busy, is ignored and does not change the line.
- R3: In the cycle after acceptance the block drives J (`dp_o`=0, `dm_o`=1) with `oe_o`=0. In the next cycle `oe_o`=1 with J still on the line. The first sync bit starts in the cycle after that.
- R4: Every line bit lasts 11 clocks. The first byte is the sync value 0x80 sent LSB first, so the line shows K J K J K J K K.
- R5: J is `dp_o`=0/`dm_o`=1 and K is `dp_o`=1/`dm_o`=0. A 0 data bit toggles the line and a 1 data bit holds it. Both lines are never high together while driving.
- R6: After six consecutive 1 data bits, one extra toggle (a stuffed 0) is inserted before the next data bit, and the run count restarts. The run continues across byte boundaries, including from the sync byte. A run that ends on the last payload bit still gets its stuffed bit before end of packet.
- R7: Payload bytes are taken on cycles where `in_valid_i` and `in_ready_o` are both 1. Exactly the packet's byte count is taken, in order. `in_ready_o` is high only while busy.
- R8: For a handshake (`is_data_i`=0), exactly one byte follows sync, whatever `len_i` holds.
- R9: End of packet is SE0 (`dp_o`=`dm_o`=0, `oe_o`=1) for 22 clocks, then J for 11 clocks. After that `oe_o`=0 with both lines low.
- R10: `busy_o` is high from the cycle after acceptance through the last J cycle of end of packet. `done_o` pulses for exactly one cycle, in the first idle cycle.
- R11: `dev_addr_o` takes `new_addr_i` in the cycle `done_o` pulses for a data packet. It is unchanged after a handshake and at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to send a packet |
| is_data_i | input | 1 | 1 = data packet, 0 = handshake |
| len_i | input | 4 | Payload byte count excluding sync (data packets) |
| in_data_i | input | 8 | Payload byte |
| in_valid_i | input | 1 | Payload byte valid |
| in_ready_o | output | 1 | Block can take a payload byte |
| new_addr_i | input | 7 | Device address to commit after a data packet |
| dev_addr_o | output | 7 | Active device address |
| dp_o | output | 1 | D+ line level |
| dm_o | output | 1 | D- line level |
| oe_o | output | 1 | Driver enable for both lines |
| busy_o | output | 1 | Packet in progress |
| done_o | output | 1 | One-cycle pulse when the bus is released |

## Verification
The bench records the line on every clock of each packet and compares it with a symbol stream that a bench function builds from the bytes. This catches a block that drops or misplaces a stuffed bit. The stress cases are all-ones payloads, where a run spans byte boundaries and a design that resets the run count per byte would miss stuffs, and a last byte ending in six ones, where a design that checks stuffing only before a data bit would go straight to SE0. Handshakes are sent with a wrong length on `len_i` to expose a block that trusts the length field. The address register is checked after each packet to catch a commit after handshakes. Out-of-range lengths and a start pulse in mid-packet are used to show that a design which accepts them would corrupt the line or restart.

// File: rtl/lsusb_tx_pkg.sv
package lsusb_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_ACQ,
        ST_SEND,
        ST_SE0,
        ST_EOPJ
    } tx_state_e;
endpackage

// File: rtl/lsusb_tx_bit_timer.sv
module lsusb_tx_bit_timer #(
    parameter int CLKS_PER_BIT = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic tick_o
);
    localparam int CNT_W = $clog2(CLKS_PER_BIT);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_BIT - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign tick_o = (cnt_q == LAST);

    always_comb begin
        if (clear_i || tick_o) cnt_d = '0;
        else                   cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/lsusb_tx_feed.sv
module lsusb_tx_feed #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LEN_W-1:0] load_cnt_i,
    input  logic             take_i,
    input  logic [7:0]       in_data_i,
    input  logic             in_valid_i,
    output logic             in_ready_o,
    output logic [7:0]       byte_o
);
    logic [LEN_W-1:0] owed_d, owed_q;
    logic             full_d, full_q;
    logic [7:0]       hold_d, hold_q;

    assign in_ready_o = (owed_q != '0) && !full_q;
    assign byte_o     = hold_q;

    always_comb begin
        owed_d = owed_q;
        full_d = full_q;
        hold_d = hold_q;
        if (load_i) begin
            owed_d = load_cnt_i;
            full_d = 1'b0;
        end else begin
            if (take_i) full_d = 1'b0;
            if (in_valid_i && in_ready_o) begin
                full_d = 1'b1;
                hold_d = in_data_i;
                owed_d = owed_q - LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owed_q <= '0;
            full_q <= 1'b0;
            hold_q <= '0;
        end else begin
            owed_q <= owed_d;
            full_q <= full_d;
            hold_q <= hold_d;
        end
    end
endmodule

// File: rtl/lsusb_tx.sv
module lsusb_tx
    import lsusb_tx_pkg::*;
#(
    parameter int          CLKS_PER_BIT = 11,
    parameter int          MAX_BYTES    = 12,
    parameter int          STUFF_RUN    = 6,
    parameter int          ADDR_W       = 7,
    parameter logic [7:0]  SYNC_BYTE    = 8'h80,
    parameter int          LEN_W        = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              is_data_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [7:0]        in_data_i,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    input  logic [ADDR_W-1:0] new_addr_i,
    output logic [ADDR_W-1:0] dev_addr_o,
    output logic              dp_o,
    output logic              dm_o,
    output logic              oe_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int MAX_PAYLOAD = MAX_BYTES - 1;
    localparam int RUN_W       = $clog2(STUFF_RUN + 1);
    localparam logic [3:0] BYTE_END = 4'd8;

    typedef struct packed {
        tx_state_e         st;
        logic [7:0]        sh;
        logic [3:0]        bidx;
        logic [RUN_W-1:0]  ones;
        logic [LEN_W-1:0]  left;
        logic              lvl;
        logic              pkt_data;
        logic              eop_half;
        logic              done;
        logic [ADDR_W-1:0] addr;
    } tx_regs_t;

    tx_regs_t r_d, r_q;

    logic             tick;
    logic             timer_clr;
    logic             feed_load;
    logic [LEN_W-1:0] feed_cnt;
    logic             feed_take;
    logic [7:0]       feed_byte;
    logic             len_ok;
    logic             step;
    logic [7:0]       cur;

    lsusb_tx_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (timer_clr),
        .tick_o  (tick)
    );

    lsusb_tx_feed #(.LEN_W(LEN_W)) u_feed (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (feed_load),
        .load_cnt_i (feed_cnt),
        .take_i     (feed_take),
        .in_data_i  (in_data_i),
        .in_valid_i (in_valid_i),
        .in_ready_o (in_ready_o),
        .byte_o     (feed_byte)
    );

    assign timer_clr = (r_q.st == ST_IDLE) || (r_q.st == ST_PREP) || (r_q.st == ST_ACQ);
    assign len_ok    = !is_data_i || ((len_i != '0) && (len_i <= LEN_W'(MAX_PAYLOAD)));
    assign feed_cnt  = is_data_i ? len_i : LEN_W'(1);
    assign step      = (r_q.st == ST_ACQ) || ((r_q.st == ST_SEND) && tick);

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        feed_load = 1'b0;
        feed_take = 1'b0;
        cur       = r_q.sh;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i && len_ok) begin
                    r_d.st       = ST_PREP;
                    r_d.lvl      = 1'b1;
                    r_d.sh       = SYNC_BYTE;
                    r_d.bidx     = '0;
                    r_d.ones     = '0;
                    r_d.left     = feed_cnt;
                    r_d.pkt_data = is_data_i;
                    feed_load    = 1'b1;
                end
            end
            ST_PREP: r_d.st = ST_ACQ;
            ST_ACQ, ST_SEND: begin
                if (step) begin
                    if (r_q.ones == RUN_W'(STUFF_RUN)) begin
                        // inserted toggle, no data consumed
                        r_d.lvl  = ~r_q.lvl;
                        r_d.ones = '0;
                        r_d.st   = ST_SEND;
                    end else if ((r_q.bidx == BYTE_END) && (r_q.left == '0)) begin
                        r_d.st       = ST_SE0;
                        r_d.eop_half = 1'b0;
                    end else begin
                        if (r_q.bidx == BYTE_END) begin
                            cur       = feed_byte;
                            feed_take = 1'b1;
                            r_d.left  = r_q.left - LEN_W'(1);
                            r_d.bidx  = 4'd1;
                        end else begin
                            r_d.bidx  = r_q.bidx + 4'd1;
                        end
                        r_d.sh = {1'b0, cur[7:1]};
                        if (cur[0]) begin
                            r_d.ones = r_q.ones + RUN_W'(1);
                        end else begin
                            r_d.lvl  = ~r_q.lvl;
                            r_d.ones = '0;
                        end
                        r_d.st = ST_SEND;
                    end
                end
            end
            ST_SE0: begin
                if (tick) begin
                    if (r_q.eop_half) r_d.st = ST_EOPJ;
                    else              r_d.eop_half = 1'b1;
                end
            end
            ST_EOPJ: begin
                if (tick) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    if (r_q.pkt_data) r_d.addr = new_addr_i;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.st       <= ST_IDLE;
            r_q.lvl      <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        oe_o = 1'b0;
        dp_o = 1'b0;
        dm_o = 1'b0;
        case (r_q.st)
            ST_PREP: dm_o = 1'b1;
            ST_ACQ: begin
                oe_o = 1'b1;
                dm_o = 1'b1;
            end
            ST_SEND: begin
                oe_o = 1'b1;
                dm_o = r_q.lvl;
                dp_o = ~r_q.lvl;
            end
            ST_SE0: oe_o = 1'b1;
            ST_EOPJ: begin
                oe_o = 1'b1;
                dm_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign busy_o     = (r_q.st != ST_IDLE);
    assign done_o     = r_q.done;
    assign dev_addr_o = r_q.addr;
endmodule

// File: rtl/lsusb_tx_checker.sv
module lsusb_tx_checker #(
    parameter int LEN_W  = 4,
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              is_data_i,
    input logic [LEN_W-1:0]  len_i,
    input logic              in_ready_o,
    input logic [ADDR_W-1:0] dev_addr_o,
    input logic              dp_o,
    input logic              dm_o,
    input logic              oe_o,
    input logic              busy_o,
    input logic              done_o
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!oe_o && !dp_o && !dm_o && !in_ready_o));

    p_bad_len_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && is_data_i && (len_i == '0)) |=> !busy_o);

    p_j_before_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_o) |-> (dm_o && !dp_o && $past(dm_o && !dp_o && busy_o)));

    p_no_se1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        oe_o |-> !(dp_o && dm_o));

    p_ready_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> busy_o);

    p_drive_while_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        oe_o |-> busy_o);

    p_done_after_j_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(oe_o && dm_o && !dp_o)));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_addr_only_at_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dev_addr_o) |-> done_o);
endmodule

bind lsusb_tx lsusb_tx_checker #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .is_data_i  (is_data_i),
    .len_i      (len_i),
    .in_ready_o (in_ready_o),
    .dev_addr_o (dev_addr_o),
    .dp_o       (dp_o),
    .dm_o       (dm_o),
    .oe_o       (oe_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
);

// File: tb/lsusb_tx_test.sv
module lsusb_tx_test;
    localparam int N = 11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       is_data = 1'b0;
    logic [3:0] len = '0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [6:0] new_addr = '0;
    logic [6:0] dev_addr;
    logic       dp, dm, oe, busy, done;

    always #5 clk = ~clk;

    lsusb_tx uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .is_data_i(is_data),
        .len_i(len), .in_data_i(in_data), .in_valid_i(in_valid),
        .in_ready_o(in_ready), .new_addr_i(new_addr), .dev_addr_o(dev_addr),
        .dp_o(dp), .dm_o(dm), .oe_o(oe), .busy_o(busy), .done_o(done)
    );

    int checks = 0;
    int fails  = 0;

    logic [7:0] pkt [0:15];
    logic [7:0] feed_q [0:15];
    int         feed_n = 0;
    int         feed_idx = 0;
    logic       exp_sym [0:255];
    logic [6:0] exp_addr = '0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // NRZI with stuffing, computed from the requirement text
    function automatic int build_syms(input int nb);
        int   n = 0;
        int   ones = 0;
        logic lv = 1'b1;
        for (int i = 0; i < nb; i++) begin
            for (int k = 0; k < 8; k++) begin
                logic b = pkt[i][k];
                if (!b) lv = ~lv;
                exp_sym[n] = lv;
                n++;
                if (b) begin
                    ones++;
                    if (ones == 6) begin
                        lv = ~lv;
                        exp_sym[n] = lv;
                        n++;
                        ones = 0;
                    end
                end else begin
                    ones = 0;
                end
            end
        end
        return n;
    endfunction

    // byte source with random gaps
    initial begin
        forever begin
            @(negedge clk);
            if (in_valid && in_ready) begin
                @(posedge clk);
                #1;
                feed_idx++;
                in_valid = 1'b0;
                repeat ($urandom % 6) @(negedge clk);
            end else if (!in_valid && feed_idx < feed_n) begin
                in_valid = 1'b1;
                in_data  = feed_q[feed_idx];
            end
        end
    end

    task automatic run_pkt(input bit isd, input logic [3:0] len_req, input int npay,
                           input logic [6:0] naddr, input bit poke, input string tag);
        int nsym, tot, mism, dmis;
        logic [3:0] first_act, first_exp;
        pkt[0] = 8'h80;
        for (int i = 0; i < npay; i++) feed_q[i] = pkt[i+1];
        feed_idx = 0;
        feed_n   = npay;
        nsym = build_syms(npay + 1);
        @(negedge clk);
        start = 1'b1; is_data = isd; len = len_req; new_addr = naddr;
        @(negedge clk);
        start = 1'b0;
        // R3: J with drivers off
        chk({busy, oe, dp, dm} == 4'b1001, "R3 prep", {busy, oe, dp, dm}, 4'b1001);
        @(negedge clk);
        chk({busy, oe, dp, dm} == 4'b1101, "R3 acquire", {busy, oe, dp, dm}, 4'b1101);
        tot = (nsym + 3) * N;
        mism = 0; dmis = 0; first_act = '0; first_exp = '0;
        for (int c = 0; c <= tot; c++) begin
            logic [3:0] e;
            @(negedge clk);
            if (poke && c == 30) begin start = 1'b1; is_data = 1'b1; len = 4'd3; end
            if (poke && c == 31) start = 1'b0;
            if (c < nsym * N)            e = {2'b11, ~exp_sym[c / N], exp_sym[c / N]};
            else if (c < (nsym + 2) * N) e = 4'b1100;
            else if (c < tot)            e = 4'b1101;
            else                         e = 4'b0000;
            if ({busy, oe, dp, dm} != e) begin
                if (mism == 0) begin first_act = {busy, oe, dp, dm}; first_exp = e; end
                mism++;
            end
            if (done != (c == tot)) dmis++;
        end
        // line trace covers R4 R5 R6 R9 and the tag given by the caller
        chk(mism == 0, {tag, " line R4 R5 R6 R9"}, first_act, first_exp);
        chk(dmis == 0, "R10 done pulse", dmis, 0);
        chk(feed_idx == npay, "R7 bytes taken", feed_idx, npay);
        if (isd) exp_addr = naddr;
        chk(dev_addr == exp_addr, "R11 address", dev_addr, exp_addr);
        @(negedge clk);
        chk({busy, done, oe, in_ready, dp, dm} == 6'b0, "R1 idle after release",
            {busy, done, oe, in_ready, dp, dm}, 0);
    endtask

    task automatic bad_start(input logic [3:0] l);
        @(negedge clk);
        start = 1'b1; is_data = 1'b1; len = l;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !oe && !in_ready, "R2 bad length ignored", {busy, oe}, 0);
    endtask

    initial begin
        #(150000 * 10);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, oe, dp, dm, in_ready, done} == 6'b0, "R1 reset outputs",
            {busy, oe, dp, dm, in_ready, done}, 0);
        chk(dev_addr == 7'd0, "R1 reset address", dev_addr, 0);

        // R8: handshake with misleading length
        pkt[1] = 8'hD2;
        run_pkt(1'b0, 4'd5, 1, 7'h15, 1'b0, "R8 ack");
        pkt[1] = 8'h5A;
        run_pkt(1'b0, 4'd0, 1, 7'h2B, 1'b0, "R8 nak");

        // R6: runs spanning bytes, start poked mid-packet (R2)
        for (int i = 1; i <= 3; i++) pkt[i] = 8'hFF;
        run_pkt(1'b1, 4'd3, 3, 7'h33, 1'b1, "R6 R2 ones");

        // R6: stuffed bit owed after the last data bit
        pkt[1] = 8'hFC;
        run_pkt(1'b1, 4'd1, 1, 7'h41, 1'b0, "R6 tail");

        // R2: longest packet
        for (int i = 1; i <= 11; i++) pkt[i] = 8'($urandom);
        run_pkt(1'b1, 4'd11, 11, 7'h5C, 1'b0, "R2 max");

        bad_start(4'd0);
        bad_start(4'd12);
        bad_start(4'd15);

        // random mix
        for (int t = 0; t < 14; t++) begin
            bit isd = ($urandom % 3) != 0;
            int np  = isd ? 1 + ($urandom % 11) : 1;
            for (int i = 1; i <= np; i++) begin
                pkt[i] = 8'($urandom);
                if ($urandom % 4 == 0) pkt[i] = 8'hFF;
            end
            run_pkt(isd, isd ? 4'(np) : 4'($urandom), np, 7'($urandom), 1'b0, "R8 R11 random");
        end
        finish_run();
    end
endmodule